// File: doc/BRIEF.md
# Fast Link Pulse Burst Transmitter

This block sends a 16-bit auto-negotiation code word as a burst of fast link pulses. A burst has 33 pulse slots. The odd slots carry clock pulses and always produce a strobe. Each even slot carries one data bit: a strobe in the slot means 1, and no strobe means 0. While negotiation is enabled, the burst repeats at a fixed period. The output is a one-cycle strobe for an external analog line driver, plus a flag that is high while a burst is in progress.

The low five bits of the transmitted word form the selector field. They always come from a parameter, with a default of 00001 for IEEE 802.3. The upper eleven ability bits come from the code word input, which is taken when each burst starts. Any of these events begins negotiation again:

- a chip reset;
- a software reset level;
- a falling edge of link status;
- a rising edge of the restart control bit.

A restart stops any burst in progress. The block then waits one full inter-burst gap and starts a new burst from slot 1. All timing comes from two cycle-count parameters: the slot spacing and the burst period.

Top module: `flp_burst_tx`

## Requirements
- R1: While `rst` is high, `pulseStrobe` and `burstActive` are low. The start condition is sampled at a clock edge where `rst` is low and `enable` is high. Exactly GAP = PERIOD_CYCLES − 33·SLOT_CYCLES edges later, `burstActive` rises.
- R2: A burst is 33 slots of SLOT_CYCLES cycles each. `burstActive` stays high for exactly 33·SLOT_CYCLES cycles and goes low in the next cycle. `pulseStrobe` can be high only in the first cycle of a slot.
- R3: Every odd slot (1, 3, …, 33) produces a strobe.
- R4: Slot 2k (k = 1…16) produces a strobe exactly when bit k−1 of the transmitted word is 1. Bits are sent least significant bit first.
- R5: The transmitted word is {codeWord[15:5], SELECTOR}, with SELECTOR defaulting to 5'b00001. codeWord[4:0] has no effect.
- R6: The code word is taken in the first cycle of a burst. A change during the burst does not affect that burst, and the new value is used in the next burst.
- R7: While no restart occurs, a burst starts exactly PERIOD_CYCLES cycles after the previous one started.
- R8: While `softRst` is high, the block restarts. `burstActive` is low after the next edge, and the next burst starts GAP edges after the last edge that sampled `softRst` high.
- R9: A falling edge of `linkUp` restarts the block, with the same abort and gap timing as R8. A rising edge of `linkUp` has no effect.
- R10: A rising edge of `restartBit` restarts the block, with the same abort and gap timing as R8. Holding `restartBit` high does not trigger another restart.
- R11: While `enable` is low, `pulseStrobe` is low in the same cycle and `burstActive` is low from the next edge. When `enable` returns high, the start timing of R1 applies.
- R12: Every strobe is exactly one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous chip reset, active high |
| enable | input | 1 | Auto-negotiation enable |
| softRst | input | 1 | Software reset level; restarts the block while high |
| linkUp | input | 1 | Link status; a falling edge restarts the block |
| restartBit | input | 1 | Restart control bit; a rising edge restarts the block |
| codeWord | input | 16 | Code word; bits 15:5 are the transmitted ability bits |
| pulseStrobe | output | 1 | One-cycle request to the analog driver to emit a pulse |
| burstActive | output | 1 | High during the 33 slots of a burst |

## Verification
On every cycle, the assertions check these properties:

- strobes are exactly one cycle wide;
- there is no strobe outside a burst or while `enable` is low;
- a burst ends after the cycle in which disable, software reset, a link-status fall or a restart rise is sampled.

Other behaviours can only be shown by the bench's scenarios:

- the bit pattern of each burst, including the forced selector and the least-significant-bit-first order;
- when the code word is captured;
- the exact lengths of the gap and of the repeat period;
- that a held restart bit does not retrigger.

// File: rtl/flp_tx_pkg.sv
package flp_tx_pkg;

  localparam int unsigned SLOTS_PER_BURST = 33;
  localparam int unsigned WORD_BITS       = 16;
  localparam int unsigned SEL_BITS        = 5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GAP   = 2'd1,
    ST_BURST = 2'd2
  } flpState_t;

  typedef struct packed {
    logic clrTimer;
    logic startBurst;
    logic nextSlot;
    logic inBurst;
  } flpCtrl_t;

endpackage

// File: rtl/flp_ctrl.sv
module flp_ctrl
  import flp_tx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     enable,
  input  logic     softRst,
  input  logic     linkUp,
  input  logic     restartBit,
  input  logic     timerLast,
  input  logic     lastSlot,
  output flpCtrl_t ctl,
  output logic     restartNow
);

  flpState_t state, stateNext;
  logic      linkPrev;
  logic      restartPrev;

  // Restart on a soft reset level, a link-status fall or a control-bit rise.
  assign restartNow = softRst | (linkPrev & ~linkUp) | (restartBit & ~restartPrev);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      linkPrev    <= 1'b1;
      restartPrev <= 1'b0;
    end else begin
      state       <= stateNext;
      linkPrev    <= linkUp;
      restartPrev <= restartBit;
    end
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    if (!enable) begin
      stateNext = ST_IDLE;
    end else if (restartNow || state == ST_IDLE) begin
      stateNext    = ST_GAP;
      ctl.clrTimer = 1'b1;
    end else begin
      case (state)
        ST_GAP: begin
          if (timerLast) begin
            stateNext      = ST_BURST;
            ctl.startBurst = 1'b1;
            ctl.clrTimer   = 1'b1;
          end
        end
        ST_BURST: begin
          if (timerLast) begin
            ctl.clrTimer = 1'b1;
            if (lastSlot) stateNext    = ST_GAP;
            else          ctl.nextSlot = 1'b1;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
    ctl.inBurst = (state == ST_BURST);
  end

endmodule

// File: rtl/flp_datapath.sv
module flp_datapath
  import flp_tx_pkg::*;
#(
  parameter int unsigned SLOT_CYCLES = 15625,
  parameter int unsigned GAP_CYCLES  = 3484375,
  parameter int unsigned TW          = 22,
  parameter logic [SEL_BITS-1:0] SELECTOR = 5'b00001
) (
  input  logic                          clk,
  input  logic                          rst,
  input  flpCtrl_t                      ctl,
  input  logic [WORD_BITS-1:SEL_BITS]   abilityBits,
  input  logic                          enable,
  input  logic                          restartNow,
  output logic                          timerLast,
  output logic                          lastSlot,
  output logic                          pulseStrobe,
  output logic                          burstActive
);

  localparam logic [TW-1:0] SLOT_LAST = TW'(SLOT_CYCLES - 1);
  localparam logic [TW-1:0] GAP_LAST  = TW'(GAP_CYCLES - 1);
  localparam int unsigned   SN_W      = $clog2(SLOTS_PER_BURST + 1);
  localparam int unsigned   PAT_W     = 2 ** SN_W;

  logic [TW-1:0]        timer;
  logic [SN_W-1:0]      slotNum;
  logic [WORD_BITS-1:0] txWord;
  logic [PAT_W-1:0]     slotPattern;

  always_ff @(posedge clk) begin
    if (rst) begin
      timer   <= '0;
      slotNum <= '0;
      txWord  <= '0;
    end else begin
      if (ctl.clrTimer) timer <= '0;
      else              timer <= timer + 1'b1;
      if (ctl.startBurst) begin
        slotNum <= SN_W'(1);
        txWord  <= {abilityBits, SELECTOR};
      end else if (ctl.nextSlot) begin
        slotNum <= slotNum + 1'b1;
      end
    end
  end

  // Odd slots are always clock pulses. Even slot 2k carries word bit k-1.
  for (genvar s = 0; s < PAT_W; s++) begin : g_slot
    if (s >= 1 && s <= SLOTS_PER_BURST && (s % 2) == 1) begin : g_clock
      assign slotPattern[s] = 1'b1;
    end else if (s >= 2 && s <= SLOTS_PER_BURST) begin : g_data
      assign slotPattern[s] = txWord[s/2 - 1];
    end else begin : g_none
      assign slotPattern[s] = 1'b0;
    end
  end

  assign timerLast   = ctl.inBurst ? (timer == SLOT_LAST) : (timer == GAP_LAST);
  assign lastSlot    = (slotNum == SN_W'(SLOTS_PER_BURST));
  assign burstActive = ctl.inBurst;
  assign pulseStrobe = ctl.inBurst & (timer == '0) & slotPattern[slotNum]
                       & enable & ~restartNow;

endmodule

// File: rtl/flp_burst_tx.sv
module flp_burst_tx
  import flp_tx_pkg::*;
#(
  parameter int unsigned SLOT_CYCLES   = 15625,
  parameter int unsigned PERIOD_CYCLES = 4000000,
  parameter logic [4:0]  SELECTOR      = 5'b00001
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        enable,
  input  logic        softRst,
  input  logic        linkUp,
  input  logic        restartBit,
  input  logic [15:0] codeWord,
  output logic        pulseStrobe,
  output logic        burstActive
);

  localparam int unsigned GAP_CYCLES = PERIOD_CYCLES - SLOTS_PER_BURST * SLOT_CYCLES;
  localparam int unsigned TW         = $clog2(PERIOD_CYCLES);

  flpCtrl_t ctl;
  logic     restartNow;
  logic     timerLast;
  logic     lastSlot;
  logic     unusedSelBits;

  // The selector field is forced, so the low input bits are not used.
  assign unusedSelBits = ^codeWord[SEL_BITS-1:0];

  flp_ctrl ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .softRst    (softRst),
    .linkUp     (linkUp),
    .restartBit (restartBit),
    .timerLast  (timerLast),
    .lastSlot   (lastSlot),
    .ctl        (ctl),
    .restartNow (restartNow)
  );

  flp_datapath #(
    .SLOT_CYCLES (SLOT_CYCLES),
    .GAP_CYCLES  (GAP_CYCLES),
    .TW          (TW),
    .SELECTOR    (SELECTOR)
  ) dp_i (
    .clk         (clk),
    .rst         (rst),
    .ctl         (ctl),
    .abilityBits (codeWord[WORD_BITS-1:SEL_BITS]),
    .enable      (enable),
    .restartNow  (restartNow),
    .timerLast   (timerLast),
    .lastSlot    (lastSlot),
    .pulseStrobe (pulseStrobe),
    .burstActive (burstActive)
  );

endmodule

// File: rtl/flp_burst_tx_chk.sv
module flp_burst_tx_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic softRst,
  input logic linkUp,
  input logic restartBit,
  input logic pulseStrobe,
  input logic burstActive
);

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pulseStrobe |=> !pulseStrobe); // R12

  AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !enable |-> !pulseStrobe); // R11

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !burstActive); // R11

  AST_STROBE_IN_BURST: assert property (@(posedge clk) disable iff (rst)
    pulseStrobe |-> burstActive); // R2

  AST_SOFT_ABORT: assert property (@(posedge clk) disable iff (rst)
    (enable && softRst) |=> !burstActive); // R8

  AST_LINK_ABORT: assert property (@(posedge clk) disable iff (rst)
    (enable && $fell(linkUp)) |=> !burstActive); // R9

  AST_RESTART_ABORT: assert property (@(posedge clk) disable iff (rst)
    (enable && $rose(restartBit)) |=> !burstActive); // R10

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |-> (!pulseStrobe && !burstActive)); // R1

endmodule

bind flp_burst_tx flp_burst_tx_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .enable      (enable),
  .softRst     (softRst),
  .linkUp      (linkUp),
  .restartBit  (restartBit),
  .pulseStrobe (pulseStrobe),
  .burstActive (burstActive)
);

// File: tb/flp_burst_tx_tb_top.sv
`timescale 1ns/1ps
module flp_burst_tx_tb_top;

  localparam int SLOT   = 4;
  localparam int PERIOD = 200;
  localparam int GAP    = PERIOD - 33 * SLOT;
  localparam logic [4:0] SEL = 5'b00001;
  localparam logic [15:0] WA = 16'hB35E;
  localparam logic [15:0] WB = 16'h6AB5;

  logic clk = 1'b0;
  logic rst, enable, softRst, linkUp, restartBit;
  logic [15:0] codeWord;
  logic pulseStrobe, burstActive;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  flp_burst_tx #(
    .SLOT_CYCLES   (SLOT),
    .PERIOD_CYCLES (PERIOD),
    .SELECTOR      (SEL)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .softRst     (softRst),
    .linkUp      (linkUp),
    .restartBit  (restartBit),
    .codeWord    (codeWord),
    .pulseStrobe (pulseStrobe),
    .burstActive (burstActive)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Counts edges until burstActive is seen high. The caller sits at a negedge.
  task automatic waitBurst(output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!burstActive && n < 10 * PERIOD);
  endtask

  // Starts in the first cycle of a burst and captures all 33 slots.
  task automatic captureBurst(input logic [15:0] expCw, input int changeAt,
                              input logic [15:0] newCw, input string tag);
    logic [33:0] pat, expPat;
    logic [15:0] txExp;
    int extra, drops;
    pat = '0; extra = 0; drops = 0;
    txExp = {expCw[15:5], SEL};
    expPat = '0;
    for (int s = 1; s <= 33; s++)
      expPat[s] = (s % 2 == 1) ? 1'b1 : txExp[s/2 - 1];
    for (int i = 0; i < 33 * SLOT; i++) begin
      if (!burstActive) drops++;
      if (i % SLOT == 0) pat[i/SLOT + 1] = pulseStrobe;
      else if (pulseStrobe) extra++;
      if (i == changeAt) codeWord = newCw;
      @(negedge clk);
    end
    check((pat & 34'h2AAAAAAAA) == 34'h2AAAAAAAA, "R3", {tag, " odd slots"},
          pat & 34'h2AAAAAAAA, 34'h2AAAAAAAA);
    check((pat & 34'h155555554) == (expPat & 34'h155555554), "R4", {tag, " even slots"},
          pat, expPat);
    check(extra == 0, "R12", {tag, " strobes off slot start"}, extra, 0);
    check(drops == 0 && !burstActive, "R2", {tag, " burst length"}, drops, 0);
  endtask

  // Applies a restart event during a burst and checks the abort and the gap.
  task automatic fireEvent(input int kind, input string req);
    int n;
    repeat (20) @(negedge clk);
    case (kind)
      0: softRst = 1'b1;
      1: linkUp = 1'b0;
      default: restartBit = 1'b1;
    endcase
    @(posedge clk);
    @(negedge clk);
    if (kind == 0) softRst = 1'b0;
    if (kind == 1) linkUp = 1'b1;
    check(!burstActive, req, "burst aborted", burstActive, 0);
    n = 1;
    while (!burstActive && n < 10 * PERIOD) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    check(n == GAP + 1, req, "restart gap", n, GAP + 1);
  endtask

  task automatic t_reset();
    int n;
    rst = 1'b1; enable = 1'b1; softRst = 1'b0; linkUp = 1'b1;
    restartBit = 1'b0; codeWord = WA;
    repeat (5) @(negedge clk);
    check(!pulseStrobe && !burstActive, "R1", "outputs in reset",
          {pulseStrobe, burstActive}, 0);
    rst = 1'b0;
    waitBurst(n);
    check(n == GAP + 1, "R1", "first burst delay", n, GAP + 1);
    // R5: WA has low bits 11110, but the selector 00001 must be sent.
    // R6: the code word changes in the middle of the burst.
    captureBurst(WA, 10 * SLOT + 1, WB, "R5 R6 first");
  endtask

  task automatic t_repeat();
    int n;
    waitBurst(n);
    check(n == GAP, "R7", "repeat period", n, GAP);
    captureBurst(WB, -1, WB, "R6 next word");
  endtask

  task automatic t_soft();
    int n;
    waitBurst(n);
    fireEvent(0, "R8");
    captureBurst(WB, -1, WB, "R8 after");
  endtask

  task automatic t_link();
    int n;
    waitBurst(n);
    fireEvent(1, "R9");
    captureBurst(WB, -1, WB, "R9 after");
  endtask

  task automatic t_restart();
    int n;
    waitBurst(n);
    fireEvent(2, "R10");
    // restartBit is still high here and must not abort this burst.
    captureBurst(WB, -1, WB, "R10 held");
    restartBit = 1'b0;
  endtask

  task automatic t_enable();
    int n, seen, act;
    waitBurst(n);
    enable = 1'b0;
    #1;
    check(!pulseStrobe, "R11", "strobe cut at disable", pulseStrobe, 0);
    seen = 0; act = 0;
    for (int i = 0; i < 2 * PERIOD; i++) begin
      @(negedge clk);
      if (pulseStrobe) seen++;
      if (burstActive) act++;
    end
    check(seen == 0 && act == 0, "R11", "quiet while disabled", seen + act, 0);
    enable = 1'b1;
    waitBurst(n);
    check(n == GAP + 1, "R11", "start after enable", n, GAP + 1);
    captureBurst(WB, -1, WB, "R11 after");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_repeat();
    t_soft();
    t_link();
    t_restart();
    t_enable();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule